// File: doc/BRIEF.md
# Board Interrupt Expander with Identification Words

This block sits inside a board-level programmable logic device and gathers up to sixteen level-sensitive interrupt requests from the board. Each request that is seen high latches a sticky bit in a status register. A per-bit mask selects which latched bits reach the host. The block drives a single active-low interrupt line to the host processor whenever any unmasked latched bit is set.

Latched bits are cleared through a separate clear register. Writing a 1 to a bit of that register holds the matching status bit at zero. Writing 0 afterwards releases the hold. Three fixed identification words and a code-revision word let host software confirm that the board is fitted before it touches anything else.

All registers are 16 bits wide. They sit behind a simple synchronous bus that has a word address, read and write strobes, write data and registered read data. Register map (word addresses): 0, 1 and 2 hold the identification words; 3 holds the code revision; 4 is status; 5 is mask; 6 is clear; 7 is the pending view; 8 to 15 are unmapped.

Top module: `brd_irq_expander`

## Requirements
- R1: Reads of addresses 0, 1 and 2 return 0xAAAA, 0x5555 and 0xCAFE respectively.
- R2: A read of address 3 returns the CODE_VER parameter. Writes to addresses 0, 1, 2, 3 and 7 change nothing that can be read back.
- R3: A status bit sets on a clock edge where its source is high and its clear bit is 0. It then stays set after the source falls. Status reads at address 4.
- R4: While a clear bit (address 6, read/write) is 1, the matching status bit is forced to 0 on every edge, even when its source is high in that cycle. Once the clear bit returns to 0, the status bit may set again.
- R5: Mask register at address 5 (read/write): a 1 disables the source and a 0 enables it. Address 7 reads status AND NOT mask.
- R6: irq_n is 0 exactly when status AND NOT mask is non-zero. It follows register changes without an added cycle.
- R7: After synchronous reset, status, mask and clear are 0x0000, irq_n is 1 and rd_data is 0x0000.
- R8: rd_data presents the addressed register one cycle after rd_en. It is 0x0000 in the cycle after no read, and also after a read of addresses 8 to 15.
- R9: After the start-up sequence (clear written 0xFFFF and then 0, then mask written 0x001F), activity on sources 0 to 4 leaves irq_n high, while source 5 drives it low.
- R10: Mask bits do not stop status bits from latching. A masked source still shows in the status read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_in | input | N_SRC | Level-sensitive interrupt sources |
| bus_addr | input | 4 | Register word address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| irq_n | output | 1 | Active-low interrupt to host |

## Verification
The assertions assume that the sources and the bus strobes are stable across each clock edge, and that a read and a write never arrive in the same cycle. The bench drives every input on the falling edge and issues one bus operation at a time. It also assumes that rst is held for at least one edge before any bus traffic, which the bench does. Sources may toggle freely. The pseudo-random phase deliberately overlaps source activity with held clear bits, so that the case where the clear wins is hit repeatedly.

// File: rtl/brd_irq_pkg.sv
package brd_irq_pkg;

    localparam int DATA_W = 16;
    localparam int ADDR_W = 4;

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic [ADDR_W-1:0] {
        RA_ID0  = 4'd0,
        RA_ID1  = 4'd1,
        RA_ID2  = 4'd2,
        RA_VER  = 4'd3,
        RA_STAT = 4'd4,
        RA_MASK = 4'd5,
        RA_CLR  = 4'd6,
        RA_PEND = 4'd7
    } reg_addr_e;

    localparam word_t ID_WORD0 = 16'hAAAA;
    localparam word_t ID_WORD1 = 16'h5555;
    localparam word_t ID_WORD2 = 16'hCAFE;

    typedef struct packed {
        logic  mask_we;
        logic  clr_we;
        word_t wdata;
    } wr_ctl_t;

    function automatic word_t id_word(input int idx);
        case (idx)
            0:       return ID_WORD0;
            1:       return ID_WORD1;
            default: return ID_WORD2;
        endcase
    endfunction

    function automatic wr_ctl_t decode_write(input logic wr, input addr_t addr, input word_t wd);
        wr_ctl_t c;
        c.mask_we = wr && (addr == RA_MASK);
        c.clr_we  = wr && (addr == RA_CLR);
        c.wdata   = wd;
        return c;
    endfunction

endpackage

// File: rtl/brd_irq_status.sv
module brd_irq_status
    import brd_irq_pkg::*;
#(
    parameter int N_SRC = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] src_in,
    input  wr_ctl_t          wctl,
    output logic [N_SRC-1:0] status_q,
    output logic [N_SRC-1:0] clr_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            clr_q <= '0;
        end else if (wctl.clr_we) begin
            clr_q <= wctl.wdata[N_SRC-1:0];
        end
    end

    for (genvar b = 0; b < N_SRC; b++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                status_q[b] <= 1'b0;
            end else if (clr_q[b]) begin
                status_q[b] <= 1'b0;
            end else if (src_in[b]) begin
                status_q[b] <= 1'b1;
            end
        end
    end

    assert_clear_wins_R4: assert property (@(posedge clk) disable iff (rst)
        (clr_q != '0) |=> ((status_q & $past(clr_q)) == '0));

    assert_sticky_R3: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((status_q & $past(status_q & ~clr_q)) == $past(status_q & ~clr_q)));

endmodule

// File: rtl/brd_irq_mask.sv
module brd_irq_mask
    import brd_irq_pkg::*;
#(
    parameter int N_SRC = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  wr_ctl_t          wctl,
    input  logic [N_SRC-1:0] status,
    output logic [N_SRC-1:0] mask_q,
    output logic [N_SRC-1:0] pend,
    output logic             irq_n
);

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
        end else if (wctl.mask_we) begin
            mask_q <= wctl.wdata[N_SRC-1:0];
        end
    end

    always_comb begin
        pend  = status & ~mask_q;
        irq_n = (pend == '0);
    end

    assert_full_mask_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        (mask_q == '1) |-> irq_n);

endmodule

// File: rtl/brd_irq_rdport.sv
module brd_irq_rdport
    import brd_irq_pkg::*;
#(
    parameter int    N_SRC    = 16,
    parameter word_t CODE_VER = 16'h0103
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rd,
    input  addr_t            addr,
    input  logic [N_SRC-1:0] status,
    input  logic [N_SRC-1:0] mask,
    input  logic [N_SRC-1:0] clr,
    input  logic [N_SRC-1:0] pend,
    output word_t            rdata
);

    localparam int N_ID = 3;

    function automatic word_t widen(input logic [N_SRC-1:0] v);
        word_t w;
        w = '0;
        w[N_SRC-1:0] = v;
        return w;
    endfunction

    word_t id_tab [N_ID];
    word_t sel;

    for (genvar i = 0; i < N_ID; i++) begin : g_id
        assign id_tab[i] = id_word(i);
    end

    always_comb begin
        case (addr)
            RA_ID0:  sel = id_tab[0];
            RA_ID1:  sel = id_tab[1];
            RA_ID2:  sel = id_tab[2];
            RA_VER:  sel = CODE_VER;
            RA_STAT: sel = widen(status);
            RA_MASK: sel = widen(mask);
            RA_CLR:  sel = widen(clr);
            RA_PEND: sel = widen(pend);
            default: sel = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else begin
            rdata <= rd ? sel : '0;
        end
    end

    assert_id0_read_R1: assert property (@(posedge clk) disable iff (rst)
        (rd && addr == RA_ID0) |=> (rdata == ID_WORD0));

    assert_idle_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (!rd) |=> (rdata == '0));

endmodule

// File: rtl/brd_irq_expander.sv
module brd_irq_expander
    import brd_irq_pkg::*;
#(
    parameter int    N_SRC    = 16,
    parameter word_t CODE_VER = 16'h0103
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] src_in,
    input  logic [3:0]       bus_addr,
    input  logic             bus_rd,
    input  logic             bus_wr,
    input  logic [15:0]      bus_wdata,
    output logic [15:0]      bus_rdata,
    output logic             irq_n
);

    wr_ctl_t          wctl;
    logic [N_SRC-1:0] status_w;
    logic [N_SRC-1:0] clr_w;
    logic [N_SRC-1:0] mask_w;
    logic [N_SRC-1:0] pend_w;

    assign wctl = decode_write(bus_wr, bus_addr, bus_wdata);

    brd_irq_status #(.N_SRC(N_SRC)) u_status (
        .clk      (clk),
        .rst      (rst),
        .src_in   (src_in),
        .wctl     (wctl),
        .status_q (status_w),
        .clr_q    (clr_w)
    );

    brd_irq_mask #(.N_SRC(N_SRC)) u_mask (
        .clk    (clk),
        .rst    (rst),
        .wctl   (wctl),
        .status (status_w),
        .mask_q (mask_w),
        .pend   (pend_w),
        .irq_n  (irq_n)
    );

    brd_irq_rdport #(.N_SRC(N_SRC), .CODE_VER(CODE_VER)) u_rdport (
        .clk    (clk),
        .rst    (rst),
        .rd     (bus_rd),
        .addr   (bus_addr),
        .status (status_w),
        .mask   (mask_w),
        .clr    (clr_w),
        .pend   (pend_w),
        .rdata  (bus_rdata)
    );

    assert_irq_follows_pending_R6: assert property (@(posedge clk) disable iff (rst)
        ((status_w & ~mask_w) != '0) |-> !irq_n);

    assert_masked_still_latch_R10: assert property (@(posedge clk) disable iff (rst)
        (src_in[0] && mask_w[0] && !clr_w[0]) |=> status_w[0]);

endmodule

// File: tb/brd_irq_expander_bench.sv
module brd_irq_expander_bench;

    localparam logic [15:0] VER = 16'h0103;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] src = '0;
    logic [3:0]  addr = '0;
    logic        rd = 1'b0;
    logic        wr = 1'b0;
    logic [15:0] wd = '0;
    logic [15:0] rdata;
    logic        irq_n;

    always #5 clk = ~clk;

    brd_irq_expander #(.N_SRC(16), .CODE_VER(VER)) u_brd_irq_expander (
        .clk       (clk),
        .rst       (rst),
        .src_in    (src),
        .bus_addr  (addr),
        .bus_rd    (rd),
        .bus_wr    (wr),
        .bus_wdata (wd),
        .bus_rdata (rdata),
        .irq_n     (irq_n)
    );

    // behavioural reference state
    int unsigned m_stat = 0, m_mask = 0, m_clr = 0, m_rd = 0;
    bit          started = 0;
    int          n_chk = 0, n_fail = 0;
    string       cur_req = "R7";

    function automatic int unsigned model_read(int a);
        case (a)
            0: return 32'hAAAA;
            1: return 32'h5555;
            2: return 32'hCAFE;
            3: return VER;
            4: return m_stat;
            5: return m_mask;
            6: return m_clr;
            7: return m_stat & ~m_mask & 32'hFFFF;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_stat = 0; m_mask = 0; m_clr = 0; m_rd = 0;
        end else begin
            int unsigned nxt;
            m_rd = rd ? model_read(addr) : 0;
            nxt  = (m_stat | src) & ~m_clr & 32'hFFFF;
            if (wr && addr == 4'd5) m_mask = wd;
            if (wr && addr == 4'd6) m_clr  = wd;
            m_stat = nxt;
        end
        started = 1;
    end

    task automatic check(string req, int unsigned act, int unsigned exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (started) begin
            check(cur_req, rdata, m_rd);
            check("R6", irq_n, ((m_stat & ~m_mask & 32'hFFFF) == 0) ? 1 : 0);
        end
    end

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rd = 0; wr = 0;
        end
    endtask

    task automatic do_wr(int a, int unsigned d);
        @(negedge clk);
        rd = 0; wr = 1; addr = 4'(a); wd = 16'(d);
        @(negedge clk);
        wr = 0;
    endtask

    task automatic do_rd(int a);
        @(negedge clk);
        wr = 0; rd = 1; addr = 4'(a);
        @(negedge clk);
        rd = 0;
    endtask

    initial begin
        #2000000;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
        $finish;
    end

    initial begin
        int unsigned lfsr;
        cur_req = "R7";
        idle(3);
        rst = 0;
        idle(2);
        cur_req = "R1";
        do_rd(0); do_rd(1); do_rd(2);
        cur_req = "R2";
        do_rd(3);
        do_wr(0, 16'h1234); do_wr(1, 16'h0); do_wr(2, 16'hFFFF);
        do_wr(3, 16'h0); do_wr(7, 16'hFFFF);
        do_rd(0); do_rd(1); do_rd(2); do_rd(3); do_rd(7); do_rd(5); do_rd(6);
        cur_req = "R8";
        do_rd(8); do_rd(15); idle(2);
        cur_req = "R3";
        @(negedge clk); src = 16'h0081;
        @(negedge clk); src = 16'h0000;
        do_rd(4); idle(2); do_rd(4);
        cur_req = "R5";
        do_wr(5, 16'h0080); do_rd(7); do_rd(5);
        do_wr(5, 16'h0081); idle(2);
        cur_req = "R10";
        @(negedge clk); src = 16'h0100;
        @(negedge clk); src = 16'h0000;
        do_wr(5, 16'hFFFF);
        @(negedge clk); src = 16'h0200;
        @(negedge clk); src = 16'h0000;
        do_rd(4); do_rd(7);
        cur_req = "R4";
        do_wr(5, 16'h0000);
        do_wr(6, 16'h0001); do_rd(4); do_rd(6);
        @(negedge clk); src = 16'h0001;
        idle(2); do_rd(4);
        do_wr(6, 16'h0000); idle(1); do_rd(4);
        @(negedge clk); src = 16'h0000;
        do_wr(6, 16'hFFFF); do_wr(6, 16'h0000); do_rd(4);
        cur_req = "R9";
        do_wr(5, 16'h001F);
        @(negedge clk); src = 16'h001F;
        idle(3); do_rd(4); do_rd(7);
        @(negedge clk); src = 16'h0020;
        @(negedge clk); src = 16'h0000;
        idle(1); do_rd(7);
        cur_req = "R6";
        lfsr = 32'hACE1;
        for (int k = 0; k < 300; k++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]} ^ (k * 32'h9E37);
            @(negedge clk);
            src = (lfsr[3:0] < 4) ? 16'(lfsr >> 7) : 16'h0;
            rd = 0; wr = 0;
            case (lfsr[10:8])
                3'd0: begin wr = 1; addr = 4'd5; wd = 16'(lfsr >> 13); end
                3'd1: begin wr = 1; addr = 4'd6; wd = 16'(lfsr >> 11) & 16'h0F0F; end
                3'd2: begin wr = 1; addr = 4'd6; wd = 16'h0; end
                3'd3, 3'd4: begin rd = 1; addr = 4'(lfsr >> 17); end
                default: ;
            endcase
        end
        @(negedge clk); rd = 0; wr = 0; src = 0;
        idle(3);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule